// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel

This block is one DMA channel. It moves data between a device address that never changes and a memory address that advances after every beat. Each beat is a read followed by a write on one shared memory request port, and the read data is written back out unchanged. The transfer is described by four 32-bit words: the device address, the memory address, a size word that packs a beat-width code with a beat count, and a link word. The link word's low two bits choose whether the chain ends or continues, and whether an interrupt pulse is raised. Its upper bits point at the next descriptor, which must be word aligned.

Software loads the four descriptor registers through a small write port while the channel is idle. It then pulses `go_i` with a mode on `mode_i`. One-shot mode runs the descriptor already held in the registers. Chained mode fetches its first descriptor from the address held in the link register and keeps following link words until one says stop. Holding `mode_i` at zero during a run cancels it. A memory error response ends the run with a sticky error flag.

Top module: `linked_dma_channel`

## Requirements
- R1: During and right after reset, `status_o` is 0 and `mem_req`, `done_o`, `irq_o` and `err_o` are all low.
- R2: A `go_i` pulse with `mode_i`=2 while idle runs the descriptor held in the registers. It does exactly `count` beats, where `count` is size bits 11:0. Each beat is one read and then one write that carries the read data unchanged. The device address is the same for every beat.
- R3: The direction input is sampled when the run starts. 1 reads from the memory address and writes to the device address; 0 reads from the device address and writes to the memory address.
- R4: Size bits 13:12 give the beat width: 0 is 4 bytes, 2 is 2 bytes and 3 is 1 byte. `mem_width` carries that code on data beats and 0 on descriptor fetches. The memory address grows by the width after each beat.
- R5: Width code 1, a count above 0x7FF with code 0, or a count above 0x3FF with codes 2 or 3, makes no data access at all. Such a run ends with the error flag set and one irq pulse.
- R6: A `go_i` pulse with `mode_i`=1 while idle reads four words from the link register's address with bits 1:0 cleared. The words at offsets 0x0, 0x4, 0x8 and 0xC load device address, memory address, size and link, in that order. After the beats, link code 2 or 3 fetches the next descriptor from that link word's address, and code 0 or 1 ends the chain.
- R7: `irq_o` pulses for one cycle at the end of each descriptor whose link bit 0 is set. This includes descriptors that are followed by another. It stays low at the end of a descriptor whose link bit 0 is clear.
- R8: `done_o` pulses once, when the run ends without error or cancel. In one-shot mode the descriptor is always the last one, whatever its link code says.
- R9: `status_o` reads 0 when idle, 1 while a descriptor is fetched or checked, 2 in the one-cycle link step, and 3 during data beats. `mem_req` is high only when the status is 1 or 3.
- R10: While the channel is not idle, `go_i` pulses, direction changes and register writes have no effect on the run in progress.
- R11: When `mode_i` is 0 while the channel is busy, the channel is idle on the next cycle with `mem_req` low. No further access is made, and neither `done_o` nor `irq_o` pulses.
- R12: A memory response with `mem_err` set stops the run. It sets `err_o`, pulses `irq_o` once, returns to idle and gives no `done_o`. `err_o` stays set until the next accepted start.
- R13: A valid descriptor with a count of 0 makes no data access. It goes straight to the link step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Descriptor register write strobe, honoured only while idle |
| reg_sel | input | 2 | Register select: 0 device address, 1 memory address, 2 size, 3 link |
| reg_wdata | input | 32 | Register write data |
| mode_i | input | 2 | 0 cancel/off, 1 chained, 2 one-shot |
| dir_i | input | 1 | 1 memory-to-device, 0 device-to-memory |
| go_i | input | 1 | Start pulse |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write access |
| mem_addr | output | 32 | Byte address of the access |
| mem_width | output | 2 | Width code of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| status_o | output | 2 | Channel state code |
| done_o | output | 1 | One-cycle pulse at the clean end of a run |
| irq_o | output | 1 | One-cycle interrupt pulse |
| err_o | output | 1 | Sticky error flag |

## Verification
The hardest situation to reach is an event that lands in the middle of a run. A cancel, a second start, a register write or a memory error has no effect unless it arrives while beats are in flight. The bench's memory model answers every request two cycles after it appears, so beat timing is fully predictable. The bench therefore counts negative edges after the start and injects the event at a known beat, and it picks the faulting address from the memory-address sequence that the width rule predicts. A two-descriptor chain is then placed in the model's memory. Its first link word says follow with interrupt, which exercises the link step, a fetch in the middle of the chain and the change of width between descriptors.

// File: rtl/linked_dma_channel.sv
module linked_dma_channel #(
  parameter int CNT_W      = 12,
  parameter int LIM_WIDE   = 'h7FF,
  parameter int LIM_NARROW = 'h3FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic [1:0]  mode_i,
  input  logic        dir_i,
  input  logic        go_i,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [1:0]  mem_width,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  output logic [1:0]  status_o,
  output logic        done_o,
  output logic        irq_o,
  output logic        err_o
);
  localparam logic [CNT_W-1:0] LIM_W = CNT_W'(LIM_WIDE);
  localparam logic [CNT_W-1:0] LIM_N = CNT_W'(LIM_NARROW);
  localparam int SZ_W = 14;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHK, S_RD, S_WR, S_LINK} st_t;
  st_t st;

  logic [31:0]      dev_q, mem_q, next_q, data_q;
  logic [SZ_W-1:0]  size_q;
  logic [31:2]      fetch_q;
  logic [1:0]       widx;
  logic [CNT_W-1:0] left_q;
  logic             oneshot_q, dir_q;

  wire [1:0]       wcode    = size_q[13:12];
  wire [CNT_W-1:0] cnt      = size_q[CNT_W-1:0];
  wire [2:0]       step     = (wcode == 2'd0) ? 3'd4 : (wcode == 2'd2) ? 3'd2 : 3'd1;
  wire             desc_bad = (wcode == 2'd1) || (cnt > ((wcode == 2'd0) ? LIM_W : LIM_N));
  wire             idle     = (st == S_IDLE);
  wire             abort    = !idle && (mode_i == 2'd0);
  wire             on_bus   = (st == S_FETCH) || (st == S_RD) || (st == S_WR);
  wire             fault    = (on_bus && mem_ack && mem_err) || (st == S_CHK && desc_bad);

  assign mem_req   = on_bus;
  assign mem_we    = (st == S_WR);
  assign mem_wdata = data_q;
  assign mem_width = (st == S_FETCH) ? 2'd0 : wcode;
  assign err_o     = err_q;

  always_comb begin
    case (st)
      S_FETCH: mem_addr = {fetch_q, 2'b00} + {28'd0, widx, 2'b00};
      S_RD:    mem_addr = dir_q ? mem_q : dev_q;
      S_WR:    mem_addr = dir_q ? dev_q : mem_q;
      default: mem_addr = 32'd0;
    endcase
    case (st)
      S_IDLE:          status_o = 2'd0;
      S_FETCH, S_CHK:  status_o = 2'd1;
      S_LINK:          status_o = 2'd2;
      default:         status_o = 2'd3;
    endcase
  end

  logic err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      dev_q <= '0; mem_q <= '0; size_q <= '0; next_q <= '0; data_q <= '0;
      fetch_q <= '0; widx <= '0; left_q <= '0;
      oneshot_q <= 1'b0; dir_q <= 1'b0;
      done_o <= 1'b0; irq_o <= 1'b0; err_q <= 1'b0;
    end else begin
      done_o <= 1'b0;
      irq_o  <= 1'b0;
      if (abort) begin
        st <= S_IDLE;
      end else if (fault) begin
        err_q <= 1'b1;
        irq_o <= 1'b1;
        st    <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: begin
            if (reg_we) begin
              case (reg_sel)
                2'd0: dev_q  <= reg_wdata;
                2'd1: mem_q  <= reg_wdata;
                2'd2: size_q <= reg_wdata[SZ_W-1:0];
                default: next_q <= reg_wdata;
              endcase
            end
            if (go_i && (mode_i == 2'd1 || mode_i == 2'd2)) begin
              dir_q     <= dir_i;
              err_q     <= 1'b0;
              oneshot_q <= (mode_i == 2'd2);
              fetch_q   <= next_q[31:2];
              widx      <= 2'd0;
              st        <= (mode_i == 2'd2) ? S_CHK : S_FETCH;
            end
          end
          S_FETCH: if (mem_ack) begin
            case (widx)
              2'd0: dev_q  <= mem_rdata;
              2'd1: mem_q  <= mem_rdata;
              2'd2: size_q <= mem_rdata[SZ_W-1:0];
              default: next_q <= mem_rdata;
            endcase
            widx <= widx + 2'd1;
            if (widx == 2'd3) st <= S_CHK;
          end
          S_CHK: begin
            left_q <= cnt;
            st     <= (cnt == '0) ? S_LINK : S_RD;
          end
          S_RD: if (mem_ack) begin
            data_q <= mem_rdata;
            st     <= S_WR;
          end
          S_WR: if (mem_ack) begin
            mem_q  <= mem_q + {29'd0, step};
            left_q <= left_q - 1'b1;
            st     <= (left_q == CNT_W'(1)) ? S_LINK : S_RD;
          end
          S_LINK: begin
            irq_o <= next_q[0];
            if (next_q[1] && !oneshot_q) begin
              fetch_q <= next_q[31:2];
              widx    <= 2'd0;
              st      <= S_FETCH;
            end else begin
              done_o <= 1'b1;
              st     <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0 && status_o != 2'd0) |=> (status_o == 2'd0 && !mem_req));

  // R2
  dev_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD || st == S_WR) |=> $stable(dev_q));

  // R10
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD || st == S_WR || st == S_LINK || st == S_CHK) && reg_we |=> ($stable(size_q) && $stable(next_q)));

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (err_o || next_q[0]));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (status_o == 2'd0 && !err_o && !mem_req));

  // R12
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (irq_o && status_o == 2'd0));

  // R9
  req_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (status_o == 2'd1 || status_o == 2'd3));
endmodule

// File: tb/linked_dma_channel_test.sv
module linked_dma_channel_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [1:0] mode_i = 2'd0;
  logic dir_i = 1'b0;
  logic go_i = 1'b0;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0] mem_width;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = 32'd0;
  logic mem_err = 1'b0;
  logic [1:0] status_o;
  logic done_o, irq_o, err_o;

  always #2.5 clk = ~clk;

  linked_dma_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mode_i(mode_i), .dir_i(dir_i), .go_i(go_i),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_width(mem_width),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .status_o(status_o), .done_o(done_o), .irq_o(irq_o), .err_o(err_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] marr [0:255];
  int n_wr, n_rd, irq_n, done_n, bad_st;
  logic [31:0] first_wa, last_wa, first_wd;
  logic [1:0] last_ww;
  logic [31:0] rd_log [0:31];
  logic [3:0] seen;
  bit err_en = 1'b0;
  logic [31:0] err_addr = 32'd0;

  function automatic logic [31:0] rd_value(input logic [31:0] a);
    return (a < 32'h400) ? marr[a[9:2]] : (a ^ 32'h5A5A_0000);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_o) irq_n++;
      if (done_o) done_n++;
      seen[status_o] = 1'b1;
      if (mem_req && !(status_o == 2'd1 || status_o == 2'd3)) bad_st++;
    end
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      mem_ack = 1'b1;
      mem_err = err_en && (mem_addr == err_addr);
      mem_rdata = rd_value(mem_addr);
      if (mem_we) begin
        if (n_wr == 0) begin first_wa = mem_addr; first_wd = mem_wdata; end
        last_wa = mem_addr;
        last_ww = mem_width;
        n_wr++;
      end else begin
        if (n_rd < 32) rd_log[n_rd] = mem_addr;
        n_rd++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic clear_logs;
    n_wr = 0; n_rd = 0; irq_n = 0; done_n = 0; bad_st = 0; seen = 4'b0;
  endtask

  task automatic kick(input logic [1:0] m, input logic d);
    mode_i = m; dir_i = d; go_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
  endtask

  task automatic wait_idle;
    int t = 0;
    while (status_o != 2'd0 && t < 20000) begin @(negedge clk); t++; end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [31:0] dv, input logic [31:0] mm, input logic [31:0] sz, input logic [31:0] nx);
    wr_reg(2'd0, dv); wr_reg(2'd1, mm); wr_reg(2'd2, sz); wr_reg(2'd3, nx);
  endtask

  typedef struct packed {
    logic        dir;
    logic [31:0] dev;
    logic [31:0] mem;
    logic [31:0] size;
    logic [31:0] next;
    logic [11:0] beats;
    logic        irq;
    logic        err;
  } vec_t;

  localparam vec_t VEC [0:8] = '{
    '{1'b1, 32'h8000_0010, 32'h0000_0040, 32'h0000_0003, 32'h1, 12'd3,    1'b1, 1'b0},
    '{1'b0, 32'h8000_0020, 32'h0000_0081, 32'h0000_3005, 32'h0, 12'd5,    1'b0, 1'b0},
    '{1'b0, 32'h8000_0030, 32'h0000_00A0, 32'h0000_2002, 32'h2, 12'd2,    1'b0, 1'b0},
    '{1'b1, 32'h8000_0040, 32'h0000_00C0, 32'h0000_0800, 32'h1, 12'd0,    1'b1, 1'b1},
    '{1'b0, 32'h8000_0044, 32'h0000_00C0, 32'h0000_3400, 32'h0, 12'd0,    1'b1, 1'b1},
    '{1'b0, 32'h8000_0050, 32'h0000_0100, 32'h0000_23FF, 32'h3, 12'd1023, 1'b1, 1'b0},
    '{1'b1, 32'h8000_0054, 32'h0000_0100, 32'h0000_1004, 32'h0, 12'd0,    1'b1, 1'b1},
    '{1'b1, 32'h8000_0058, 32'h0000_0100, 32'h0000_0000, 32'h1, 12'd0,    1'b1, 1'b0},
    '{1'b1, 32'h8000_0060, 32'h0000_0000, 32'h0000_07FF, 32'h0, 12'd2047, 1'b0, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) marr[i] = 32'hC0DE_0000 + i;
    clear_logs();
    repeat (3) @(negedge clk);
    chk("R1 status in reset", {30'd0, status_o}, 0);
    chk("R1 outputs in reset", {28'd0, mem_req, done_o, irq_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", {30'd0, status_o}, 0);
    chk("R1 req after reset", {31'd0, mem_req}, 0);

    for (int v = 0; v < 9; v++) begin
      logic [2:0] stp;
      logic [31:0] rd_a, wr_first, wr_last;
      stp = (VEC[v].size[13:12] == 2'd0) ? 3'd4 : (VEC[v].size[13:12] == 2'd2) ? 3'd2 : 3'd1;
      rd_a = VEC[v].dir ? VEC[v].mem : VEC[v].dev;
      wr_first = VEC[v].dir ? VEC[v].dev : VEC[v].mem;
      wr_last = VEC[v].dir ? VEC[v].dev : VEC[v].mem + stp * (VEC[v].beats - 1);
      load(VEC[v].dev, VEC[v].mem, VEC[v].size, VEC[v].next);
      clear_logs();
      kick(2'd2, VEC[v].dir);
      wait_idle();
      chk($sformatf("R2 R5 R13 beat count v%0d", v), n_wr, VEC[v].beats);
      chk($sformatf("R2 read count v%0d", v), n_rd, VEC[v].beats);
      chk($sformatf("R5 R12 error flag v%0d", v), {31'd0, err_o}, {31'd0, VEC[v].err});
      chk($sformatf("R7 irq pulses v%0d", v), irq_n, {31'd0, VEC[v].irq});
      chk($sformatf("R8 done pulses v%0d", v), done_n, {31'd0, !VEC[v].err});
      if (VEC[v].beats != 0) begin
        chk($sformatf("R3 first read addr v%0d", v), rd_log[0], rd_a);
        chk($sformatf("R3 first write addr v%0d", v), first_wa, wr_first);
        chk($sformatf("R2 R4 last write addr v%0d", v), last_wa, wr_last);
        chk($sformatf("R2 data v%0d", v), first_wd, rd_value(rd_a));
        chk($sformatf("R4 width code v%0d", v), {30'd0, last_ww}, {30'd0, VEC[v].size[13:12]});
      end
    end

    // R6 R9: two-descriptor chain
    marr[8'h40] = 32'h8000_0070; marr[8'h41] = 32'h0000_0200;
    marr[8'h42] = 32'h0000_0002; marr[8'h43] = 32'h0000_0123;
    marr[8'h48] = 32'h8000_0080; marr[8'h49] = 32'h0000_0240;
    marr[8'h4A] = 32'h0000_3003; marr[8'h4B] = 32'h0000_0001;
    wr_reg(2'd3, 32'h0000_0100);
    clear_logs();
    kick(2'd1, 1'b1);
    wait_idle();
    chk("R6 total beats", n_wr, 5);
    chk("R6 total reads", n_rd, 13);
    chk("R6 fetch word0", rd_log[0], 32'h100);
    chk("R6 fetch word3", rd_log[3], 32'h10C);
    chk("R6 first data read", rd_log[4], 32'h200);
    chk("R6 second fetch", rd_log[6], 32'h120);
    chk("R4 R6 byte step", rd_log[12], 32'h242);
    chk("R6 first write data", first_wd, 32'hC0DE_0080);
    chk("R6 last write addr", last_wa, 32'h8000_0080);
    chk("R4 R6 last width", {30'd0, last_ww}, 3);
    chk("R7 chain irq pulses", irq_n, 2);
    chk("R8 chain done", done_n, 1);
    chk("R9 states seen", {28'd0, seen}, 32'hF);
    chk("R9 req only in fetch or data", bad_st, 0);

    // R10: start, direction and register write during a run
    load(32'h8000_0200, 32'h0000_0200, 32'h0000_0014, 32'h0);
    clear_logs();
    kick(2'd2, 1'b0);
    repeat (5) @(negedge clk);
    wr_reg(2'd1, 32'h0000_03F0);
    kick(2'd2, 1'b1);
    wait_idle();
    chk("R10 beats unchanged", n_wr, 20);
    chk("R10 first write addr", first_wa, 32'h200);
    chk("R10 last write addr", last_wa, 32'h24C);
    chk("R10 single done", done_n, 1);

    // R11: cancel mid-run
    load(32'h8000_0300, 32'h0000_0300, 32'h0000_0032, 32'h1);
    clear_logs();
    kick(2'd2, 1'b0);
    repeat (9) @(negedge clk);
    mode_i = 2'd0;
    @(negedge clk);
    chk("R11 idle next cycle", {30'd0, status_o}, 0);
    chk("R11 no request", {31'd0, mem_req}, 0);
    begin
      int nw;
      nw = n_wr;
      repeat (6) @(negedge clk);
      chk("R11 no further writes", n_wr, nw);
    end
    chk("R11 no done", done_n, 0);
    chk("R11 no irq", irq_n, 0);

    // R12: memory error on the third read
    load(32'h8000_0400, 32'h0000_0200, 32'h0000_0005, 32'h0);
    err_en = 1'b1; err_addr = 32'h0000_0208;
    clear_logs();
    kick(2'd2, 1'b1);
    wait_idle();
    err_en = 1'b0;
    chk("R12 beats before error", n_wr, 2);
    chk("R12 error flag", {31'd0, err_o}, 1);
    chk("R12 irq once", irq_n, 1);
    chk("R12 no done", done_n, 0);
    chk("R12 idle", {30'd0, status_o}, 0);
    load(32'h8000_0400, 32'h0000_0200, 32'h0000_0000, 32'h0);
    clear_logs();
    kick(2'd2, 1'b1);
    wait_idle();
    chk("R12 flag cleared by start", {31'd0, err_o}, 0);
    chk("R13 zero count no access", n_rd + n_wr, 0);
    chk("R7 no irq when bit clear", irq_n, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule